// File: doc/BRIEF.md
# Decision-Replay State-Metric Recursion Unit

This block is a reduced-cost second recursion engine for a soft-output trellis decoder. A full max-star recursion unit elsewhere in the datapath compares two candidate metrics per state, takes the larger one and adds a small correction term. For every state it exports, on every step, the one-bit outcome of that comparison and the correction value it applied. This unit captures those decision/offset pairs, keeps them for exactly `DEPTH` steps, and then replays them. For each state it uses the stored bit to pick one predecessor metric and its branch metric, adds them, and adds the stored correction. The unit has no comparator and no correction lookup, yet it rebuilds the same metric sequence `DEPTH` steps later.

The unit is driven by a step strobe that carries one decision/offset vector per step. It also takes the branch metrics that belong to the step being replayed, and a load port that seeds the metric register at the start of each block with the vector the full unit held `DEPTH` steps earlier. A two-state controller governs it. In FILL, steps only write the delay store. When the `DEPTH`-th step is captured, the transition "store primed" moves it to RUN. In RUN, every step both captures a new entry and replays the oldest one. Only reset returns the controller to FILL.

Top module: `replay_recursion_unit`

## Requirements
- R1: After reset, `metric_out` is all zero, `out_valid` is low and the controller is in FILL.
- R2: In FILL, steps only write the delay store. `out_valid` stays low, and `metric_out` changes only through a load.
- R3: The decision/offset vector captured on the n-th step since reset is the one used by the replay on step n+`DEPTH`. Steps are counted only on cycles with `step_en` high.
- R4: On a RUN step, for each state s the new metric is (dec ? m[p1]+bm1 : m[p0]+bm0) + ofs, modulo 2^`MW`, where p0=(2s) mod `NS` and p1=(2s+1) mod `NS`. Inputs are packed with the state index as the outer index. Bit s of `dec_in` is the decision for state s. `ofs_in[s*OW +: OW]` is its offset. `bm_in[(2s+b)*BW +: BW]` is the branch metric from predecessor pb. `ld_metric` and `metric_out` hold state s at `[s*MW +: MW]`.
- R5: Suppose the unit is loaded with the reference recursion's vector from before step k, and is fed step k's branch metrics on replay step k+`DEPTH`. Then `metric_out` after that replay equals the full max-star unit's vector after step k.
- R6: `ld_en` on a cycle that is not a RUN step sets `metric_out` to `ld_metric` on the next cycle and leaves `out_valid` low.
- R7: When `ld_en` and a RUN step coincide, the replay starts from `ld_metric` instead of the held vector.
- R8: A cycle with neither `step_en` nor `ld_en` holds `metric_out`, drives `out_valid` low and does not advance the delay store.
- R9: `out_valid` is high on exactly the cycle after each RUN step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | One recursion step: capture the input vector and, in RUN, replay |
| dec_in | input | NS | Decision bits from the full unit, one per state |
| ofs_in | input | NS*OW | Correction offsets from the full unit |
| bm_in | input | NS*2*BW | Branch metrics for the step being replayed |
| ld_en | input | 1 | Load the metric register (block start) |
| ld_metric | input | NS*MW | Seed metric vector |
| metric_out | output | NS*MW | Replayed state-metric vector |
| out_valid | output | 1 | A new replayed vector is on `metric_out` |

## Verification
The in-RTL assertions watch the control properties on every cycle. They check that an idle cycle freezes the output, that a load alone lands on the output one cycle later, that no valid appears in FILL or without a preceding step, and that the store pointer stays in range. The arithmetic cannot be shown that way. That `metric_out` reproduces a compare-based max-star recursion exactly `DEPTH` steps later, through idle gaps and block reloads, comes only from the bench's long scenario against its own reference trellis.

// File: rtl/replay_pkg.sv
package replay_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } replay_state_t;

    function automatic int pred_state(input int s, input int b, input int ns);
        return (2 * s + b) % ns;
    endfunction
endpackage

// File: rtl/decision_delay_line.sv
module decision_delay_line #(
    parameter int DEPTH = 8,
    parameter int EW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] wr_data,
    output logic [EW-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wp;

    // oldest entry sits where the next write lands
    assign rd_data = mem[wp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
        end else if (push) begin
            wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= wr_data;
        end
    end

    // R3
    wp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wp) < DEPTH);

    // R8
    wp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(wp));
endmodule

// File: rtl/replay_lane.sv
module replay_lane #(
    parameter int MW = 12,
    parameter int BW = 4,
    parameter int OW = 3
) (
    input  logic [MW-1:0] m_p0,
    input  logic [MW-1:0] m_p1,
    input  logic [BW-1:0] bm0,
    input  logic [BW-1:0] bm1,
    input  logic          dec,
    input  logic [OW-1:0] ofs,
    output logic [MW-1:0] nxt
);
    logic [MW-1:0] picked;

    always_comb begin
        picked = dec ? (m_p1 + MW'(bm1)) : (m_p0 + MW'(bm0));
        nxt    = picked + MW'(ofs);
    end
endmodule

// File: rtl/replay_recursion_unit.sv
module replay_recursion_unit
    import replay_pkg::*;
#(
    parameter int NS    = 4,
    parameter int MW    = 12,
    parameter int BW    = 4,
    parameter int OW    = 3,
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic [NS-1:0]      dec_in,
    input  logic [NS*OW-1:0]   ofs_in,
    input  logic [NS*2*BW-1:0] bm_in,
    input  logic               ld_en,
    input  logic [NS*MW-1:0]   ld_metric,
    output logic [NS*MW-1:0]   metric_out,
    output logic               out_valid
);
    localparam int EW = NS * (1 + OW);
    localparam int CW = $clog2(DEPTH + 1);

    replay_state_t state_q, state_d;
    logic [CW-1:0]    fill_cnt;
    logic [EW-1:0]    old_entry;
    logic [NS-1:0]    old_dec;
    logic [NS*OW-1:0] old_ofs;
    logic [NS*MW-1:0] base_vec;
    logic [NS*MW-1:0] nxt_vec;
    logic [NS*MW-1:0] metric_q;
    logic             vld_q;
    logic             run_step;

    decision_delay_line #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (step_en),
        .wr_data ({ofs_in, dec_in}),
        .rd_data (old_entry)
    );

    assign old_dec  = old_entry[NS-1:0];
    assign old_ofs  = old_entry[EW-1:NS];
    assign base_vec = ld_en ? ld_metric : metric_q;
    assign run_step = step_en && (state_q == ST_RUN);

    for (genvar s = 0; s < NS; s++) begin : g_lane
        localparam int P0 = pred_state(s, 0, NS);
        localparam int P1 = pred_state(s, 1, NS);
        replay_lane #(.MW(MW), .BW(BW), .OW(OW)) u_lane (
            .m_p0 (base_vec[P0*MW +: MW]),
            .m_p1 (base_vec[P1*MW +: MW]),
            .bm0  (bm_in[(2*s)*BW +: BW]),
            .bm1  (bm_in[(2*s+1)*BW +: BW]),
            .dec  (old_dec[s]),
            .ofs  (old_ofs[s*OW +: OW]),
            .nxt  (nxt_vec[s*MW +: MW])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (step_en && fill_cnt == CW'(DEPTH - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (step_en && state_q == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            metric_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= run_step;
            if (run_step)   metric_q <= nxt_vec;
            else if (ld_en) metric_q <= ld_metric;
        end
    end

    assign metric_out = metric_q;
    assign out_valid  = vld_q;

    // R9
    valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(step_en));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !ld_en) |=> ($stable(metric_out) && !out_valid));

    // R6
    load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !run_step) |=> (metric_out == $past(ld_metric)));

    // R2
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |=> !out_valid);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fill_cnt) <= DEPTH);
endmodule

// File: tb/replay_recursion_unit_tb.sv
module replay_recursion_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4, MW = 12, BW = 4, OW = 3, DEPTH = 8;
    localparam int NSTEP = 40;
    localparam logic [31:0] BMTAB [8] = '{
        32'h3A1F_0C52, 32'h0917_E4B6, 32'hF00D_2C81, 32'h5555_AAAA,
        32'h1E2D_3C4B, 32'h7F31_0802, 32'hC6A9_4D17, 32'h0000_FFFF
    };

    logic clk = 0, rst_n = 0, step_en = 0, ld_en = 0;
    logic [NS-1:0]      dec_in = '0;
    logic [NS*OW-1:0]   ofs_in = '0;
    logic [NS*2*BW-1:0] bm_in = '0;
    logic [NS*MW-1:0]   ld_metric = '0;
    logic [NS*MW-1:0]   metric_out;
    logic               out_valid;

    int checks = 0, errors = 0;
    int fm [0:NSTEP][0:NS-1];
    logic [NS-1:0]      dect [NSTEP];
    logic [NS*OW-1:0]   ofst [NSTEP];
    logic [NS*2*BW-1:0] bmt  [NSTEP];

    always #(CLK_PERIOD/2) clk = ~clk;

    replay_recursion_unit #(.NS(NS), .MW(MW), .BW(BW), .OW(OW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .dec_in(dec_in), .ofs_in(ofs_in),
        .bm_in(bm_in), .ld_en(ld_en), .ld_metric(ld_metric),
        .metric_out(metric_out), .out_valid(out_valid)
    );

    function automatic int corr(input int d);
        case (d)
            0: return 5;
            1: return 4;
            2: return 3;
            3, 4: return 2;
            5, 6, 7: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [NS*MW-1:0] pack_fm(input int k);
        logic [NS*MW-1:0] v;
        for (int s = 0; s < NS; s++) v[s*MW +: MW] = MW'(fm[k][s]);
        return v;
    endfunction

    // bench's own replay equation (R4) on an arbitrary base vector
    function automatic logic [NS*MW-1:0] replay_exp(input logic [NS*MW-1:0] base, input int k);
        logic [NS*MW-1:0] v;
        for (int s = 0; s < NS; s++) begin
            logic [MW-1:0] a;
            if (dect[k][s]) a = base[((2*s+1)%NS)*MW +: MW] + MW'(bmt[k][(2*s+1)*BW +: BW]);
            else            a = base[((2*s)%NS)*MW +: MW] + MW'(bmt[k][(2*s)*BW +: BW]);
            v[s*MW +: MW] = a + MW'(ofst[k][s*OW +: OW]);
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [NS*MW-1:0] act, input logic [NS*MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic ld);
        @(negedge clk);
        step_en = st;
        ld_en   = ld;
        @(posedge clk);
        #1;
        @(negedge clk);
        step_en = 0;
        ld_en   = 0;
    endtask

    // reference full max-star recursion
    initial begin
        fm[0] = '{0, 7, 3, 9};
        for (int j = 0; j < NSTEP; j++) begin
            int sh;
            sh = (j % 5) * 4;
            bmt[j] = (BMTAB[j % 8] << sh) | ((sh == 0) ? 32'h0 : (BMTAB[j % 8] >> (32 - sh)));
            for (int s = 0; s < NS; s++) begin
                int c0, c1, mx, df;
                c0 = fm[j][(2*s)%NS]   + int'(bmt[j][(2*s)*BW +: BW]);
                c1 = fm[j][(2*s+1)%NS] + int'(bmt[j][(2*s+1)*BW +: BW]);
                dect[j][s] = (c1 > c0);
                mx = (c1 > c0) ? c1 : c0;
                df = (c1 > c0) ? c1 - c0 : c0 - c1;
                ofst[j][s*OW +: OW] = OW'(corr(df));
                fm[j+1][s] = mx + corr(df);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 metric", metric_out, '0);
        chk("R1 valid", {{(NS*MW-1){1'b0}}, out_valid}, '0);

        // R2 fill phase: capture only
        for (int j = 0; j < DEPTH; j++) begin
            dec_in = dect[j]; ofs_in = ofst[j]; bm_in = bmt[j];
            cyc(1, 0);
            chk("R2 fill metric", metric_out, '0);
            chk("R2 fill valid", {{(NS*MW-1){1'b0}}, out_valid}, '0);
            if (j == 3) begin
                cyc(0, 0); // R8 idle inside fill must not shift alignment
                chk("R8 idle in fill", metric_out, '0);
            end
        end

        // R6 load alone
        ld_metric = pack_fm(0);
        cyc(0, 1);
        chk("R6 load metric", metric_out, pack_fm(0));
        chk("R6 load valid", {{(NS*MW-1){1'b0}}, out_valid}, '0);

        // R8 idle hold
        cyc(0, 0);
        chk("R8 idle hold", metric_out, pack_fm(0));

        // main table walk: R3 R5 R9
        for (int k = 0; k + DEPTH < NSTEP; k++) begin
            dec_in = dect[k + DEPTH]; ofs_in = ofst[k + DEPTH]; bm_in = bmt[k];
            if (k == 10) begin
                cyc(0, 0);
                chk("R8 idle in run", metric_out, pack_fm(10));
                chk("R8 idle valid", {{(NS*MW-1){1'b0}}, out_valid}, '0);
            end
            if (k == 20) begin
                logic [NS*MW-1:0] cv;
                cv = {12'd100, 12'd4, 12'd55, 12'd4090};
                ld_metric = cv;
                cyc(1, 1);
                chk("R7/R4 custom seed replay", metric_out, replay_exp(cv, k));
            end else if (k == 21) begin
                ld_metric = pack_fm(21);
                cyc(1, 1);
                chk("R7 reload with step", metric_out, pack_fm(22));
            end else begin
                cyc(1, 0);
                chk("R5 R3 replay match", metric_out, pack_fm(k + 1));
            end
            chk("R9 valid", {{(NS*MW-1){1'b0}}, out_valid}, {{(NS*MW-1){1'b0}}, 1'b1});
        end

        // R9 valid drops after last step
        cyc(0, 0);
        chk("R9 valid low", {{(NS*MW-1){1'b0}}, out_valid}, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule